// File: doc/BRIEF.md
# Shadow-Memory Store and Recall Controller

This block sequences a small memory whose volatile array sits next to a nonvolatile shadow copy of the same size. Normal reads and writes go to the volatile array under active-low chip-select, output-enable and write-enable controls. A whole-array transfer copies the volatile array into the shadow (a store) or the shadow back into the volatile array (a recall). No reads or writes are accepted while a transfer is running.

A store can start in three ways. An external agent can pull the shared open-drain busy line low. A power-fail flag can be raised. A software command pulse can be given. The first two are honoured only when the volatile array has been written since the last transfer. The software command always runs. After a store is accepted, a grace window lets a write that is already under way finish before the copy. During the store the controller pulls the busy line low itself. Afterwards it stays locked until it sees the line high again. A recall is started by its own pulse.

The busy line is split into a sensed input and a pull-down enable output. The board, or the bench, combines them as a wired-AND.

Top module: `nvmem_shadow_ctrl`

## Requirements
- R1: A read is accepted only when cs_n and oe_n are 0 and we_n and busy_in are 1. The addressed byte appears on rdata, with rd_valid at 1, one cycle later. With oe_n at 1 no read is reported.
- R2: A write is accepted only when cs_n and we_n are 0 and busy_in is 1 (see R7 for the one exception). With cs_n at 1 the array is left unchanged.
- R3: A store copies the whole volatile array into the shadow, and a recall copies the whole shadow into the volatile array. Reads and writes are refused while either transfer runs.
- R4: A written flag is set by every accepted write and cleared by every store and every recall.
- R5: A store request from busy_in low or from pwr_fail high is ignored while the written flag is clear.
- R6: A sw_store pulse starts a store even when the written flag is clear.
- R7: busy_pd rises GRACE_CYC+1 cycles after the cycle in which the trigger is sampled. A write whose we_n stayed low from before busy_in fell keeps being accepted during the window.
- R8: A write that begins after busy_in has gone low is refused.
- R9: busy_pd stays at 1 for exactly STORE_CYC cycles of every store and is 0 at all other times.
- R10: After a store ends, the controller ignores all triggers, a sw_store pulse included, until busy_in is sensed at 1.
- R11: A recall_req pulse blocks reads for RECALL_CYC cycles. Reads are accepted again after that.
- R12: Store triggers that arrive in the same cycle merge into a single store.
- R13: After reset, busy_pd, rd_valid and rdata are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| rd_valid | output | 1 | rdata holds the result of an accepted read |
| busy_in | input | 1 | Sensed level of the shared open-drain busy/request line |
| busy_pd | output | 1 | Pull-down enable for the busy line, 1 during a store |
| sw_store | input | 1 | Software store command pulse |
| pwr_fail | input | 1 | Power-fail flag |
| recall_req | input | 1 | Recall command pulse |

## Verification
The bench builds the block with an 8-byte array, a 4-cycle grace window, 6-cycle stores and 3-cycle recalls. With these short windows a single run can cover a store whose write is carried through the grace window, a rejected new write and the post-store lockout. It can also confirm by recall what reached the shadow array. The exact rise and fall cycles of busy_pd are checked, and no second store may follow merged triggers.

// File: rtl/nvx_pkg.sv
package nvx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GRACE,
    ST_STORE,
    ST_LOCK,
    ST_RECALL
  } nvx_state_e;
endpackage

// File: rtl/nvx_access_decode.sv
module nvx_access_decode (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic line_hi,
  input  logic blocked,
  output logic rd_ok,
  output logic wr_ok
);
  logic wr_req;
  logic carry_q; // a write was accepted last cycle

  assign wr_req = !cs_n && !we_n;
  assign wr_ok  = wr_req && !blocked && (line_hi || carry_q);
  assign rd_ok  = !cs_n && !oe_n && we_n && line_hi && !blocked;

  always_ff @(posedge clk) begin
    if (rst) carry_q <= 1'b0;
    else     carry_q <= wr_ok;
  end

  // R8: while the line is low only a continuing write may land
  a_r8_no_fresh_write: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && !line_hi) |-> $past(wr_ok));
endmodule

// File: rtl/nvx_seq.sv
module nvx_seq
  import nvx_pkg::*;
#(
  parameter int GRACE_CYC  = 16,
  parameter int STORE_CYC  = 64,
  parameter int RECALL_CYC = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic line_hi,
  input  logic sw_store,
  input  logic pwr_fail,
  input  logic recall_req,
  input  logic wr_ok,
  output logic blocked,
  output logic pull_dn,
  output logic do_store,
  output logic do_recall
);
  localparam int MAX_A = (GRACE_CYC > STORE_CYC) ? GRACE_CYC : STORE_CYC;
  localparam int MAX_C = (MAX_A > RECALL_CYC) ? MAX_A : RECALL_CYC;
  localparam int CNT_W = (MAX_C > 1) ? $clog2(MAX_C) : 1;
  localparam logic [CNT_W-1:0] G_LAST = CNT_W'(GRACE_CYC - 1);
  localparam logic [CNT_W-1:0] S_LAST = CNT_W'(STORE_CYC - 1);
  localparam logic [CNT_W-1:0] R_LAST = CNT_W'(RECALL_CYC - 1);

  nvx_state_e       state, state_n;
  logic [CNT_W-1:0] cnt;
  logic             dirty;
  logic             store_trig;

  assign store_trig = sw_store || (dirty && (!line_hi || pwr_fail));

  always_comb begin
    state_n = state;
    case (state)
      ST_IDLE:   if (store_trig) state_n = ST_GRACE;
                 else if (recall_req) state_n = ST_RECALL;
      ST_GRACE:  if (cnt == G_LAST) state_n = ST_STORE;
      ST_STORE:  if (cnt == S_LAST) state_n = ST_LOCK;
      ST_LOCK:   if (line_hi) state_n = ST_IDLE;
      ST_RECALL: if (cnt == R_LAST) state_n = ST_IDLE;
      default:   state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      pull_dn <= 1'b0;
    end else begin
      state   <= state_n;
      cnt     <= (state_n != state) ? '0 : cnt + CNT_W'(1);
      pull_dn <= (state_n == ST_STORE);
    end
  end

  assign blocked   = (state == ST_STORE) || (state == ST_LOCK) || (state == ST_RECALL);
  assign do_store  = (state == ST_STORE)  && (cnt == '0);
  assign do_recall = (state == ST_RECALL) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)                        dirty <= 1'b0;
    else if (do_store || do_recall) dirty <= 1'b0;
    else if (wr_ok)                 dirty <= 1'b1;
  end

  // R4: the flag is clear once the first store cycle has passed
  a_r4_flag_cleared: assert property (@(posedge clk) disable iff (rst)
    $rose(pull_dn) |=> !dirty);
  // R5: a clean array with no software command never enters the grace window
  a_r5_clean_skip: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !dirty && !sw_store) |=> (state != ST_GRACE));
  // R10: locked state holds and stays blocked while the line is low
  a_r10_lock_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCK && !line_hi) |=> (blocked && !pull_dn));
endmodule

// File: rtl/nvx_arrays.sv
module nvx_arrays #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              do_store,
  input  logic              do_recall,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] vol [DEPTH];
  logic [DATA_W-1:0] shd [DEPTH];

  always_ff @(posedge clk) begin
    if (do_recall) begin
      for (int i = 0; i < DEPTH; i++) vol[i] <= shd[i];
    end else if (wr_en) begin
      vol[addr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (do_store) begin
      for (int i = 0; i < DEPTH; i++) shd[i] <= vol[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rdata    <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= vol[addr];
    end
  end
endmodule

// File: rtl/nvmem_shadow_ctrl.sv
module nvmem_shadow_ctrl #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int GRACE_CYC  = 16,
  parameter int STORE_CYC  = 64,
  parameter int RECALL_CYC = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  input  logic              busy_in,
  output logic              busy_pd,
  input  logic              sw_store,
  input  logic              pwr_fail,
  input  logic              recall_req
);
  logic rd_ok, wr_ok, blocked, do_store, do_recall;

  nvx_access_decode u_dec (
    .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .line_hi(busy_in), .blocked(blocked), .rd_ok(rd_ok), .wr_ok(wr_ok)
  );

  nvx_seq #(
    .GRACE_CYC(GRACE_CYC), .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .line_hi(busy_in), .sw_store(sw_store),
    .pwr_fail(pwr_fail), .recall_req(recall_req), .wr_ok(wr_ok),
    .blocked(blocked), .pull_dn(busy_pd), .do_store(do_store),
    .do_recall(do_recall)
  );

  nvx_arrays #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_ok),
    .rd_en(rd_ok), .do_store(do_store), .do_recall(do_recall),
    .rdata(rdata), .rd_valid(rd_valid)
  );

  // R1: a reported read was requested with the proper control levels
  a_r1_read_ctrl: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!cs_n && !oe_n && we_n && busy_in));
  // R2: writes need the write controls and never land during a store
  a_r2_write_ctrl: assert property (@(posedge clk) disable iff (rst)
    wr_ok |-> (!cs_n && !we_n && !busy_pd));
  // R3: no read result follows a cycle with a transfer under way
  a_r3_no_read_in_xfer: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!busy_pd));
endmodule

// File: tb/tb_nvmem_shadow_ctrl.sv
module tb_nvmem_shadow_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int G  = 4;
  localparam int S  = 6;
  localparam int RC = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rd_valid, busy_pd, busy_in;
  logic sw_store = 1'b0, pwr_fail = 1'b0, recall_req = 1'b0;
  logic ext_low = 1'b0;

  assign busy_in = !(busy_pd || ext_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  nvmem_shadow_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .GRACE_CYC(G), .STORE_CYC(S), .RECALL_CYC(RC)
  ) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .busy_in(busy_in), .busy_pd(busy_pd), .sw_store(sw_store),
    .pwr_fail(pwr_fail), .recall_req(recall_req)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] m_vol [DEPTH];
  logic [DW-1:0] m_shd [DEPTH];
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R1 unexpected read: actual %0d expected none", rdata);
      end else begin
        string t;
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, int'(rdata), int'(e));
      end
    end
  end

  task automatic bus_idle();
    cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic wr(input int a, input int d);
    cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    addr = AW'(a); wdata = DW'(d);
    @(negedge clk);
    bus_idle();
    m_vol[a] = DW'(d);
  endtask

  task automatic rd(input int a, input string tag);
    cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = AW'(a);
    exp_q.push_back(m_vol[a]);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_idle();
  endtask

  task automatic rd_block(input int a, input string tag);
    cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = AW'(a);
    @(negedge clk);
    bus_idle();
    @(negedge clk);
    chk(tag, int'(rd_valid), 0);
  endtask

  task automatic no_store(input int n, input string tag);
    int hits = 0;
    repeat (n) begin
      @(negedge clk);
      if (busy_pd) hits++;
    end
    chk(tag, hits, 0);
  endtask

  // trigger presented 'done' negedges ago; checks rise and fall of busy_pd
  task automatic store_window(input int done, input string tag);
    repeat (G - done) begin
      @(negedge clk);
      sw_store = 1'b0; pwr_fail = 1'b0;
    end
    chk({tag, " R7 no pull before window end"}, int'(busy_pd), 0);
    @(negedge clk);
    chk({tag, " R7 pull starts"}, int'(busy_pd), 1);
    repeat (S - 1) @(negedge clk);
    chk({tag, " R9 pull held"}, int'(busy_pd), 1);
    @(negedge clk);
    chk({tag, " R9 pull released"}, int'(busy_pd), 0);
    for (int i = 0; i < DEPTH; i++) m_shd[i] = m_vol[i];
  endtask

  initial begin
    bit done = 0;
    fork
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk("R13 busy_pd after reset", int'(busy_pd), 0);
        chk("R13 rd_valid after reset", int'(rd_valid), 0);
        chk("R13 rdata after reset", int'(rdata), 0);

        // R5: clean flag, hardware request ignored
        ext_low = 1'b1;
        no_store(3, "R5 clean hw request");
        ext_low = 1'b0;
        no_store(G + S + 2, "R5 clean hw request after release");

        // fill and read back: R2, R1
        for (int a = 0; a < DEPTH; a++) wr(a, a * 17 + 3);
        for (int a = 0; a < DEPTH; a++) rd(a, "R1 R2 read back");
        cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; addr = 3'd1;
        @(negedge clk); bus_idle(); @(negedge clk);
        chk("R1 no read with oe_n high", int'(rd_valid), 0);
        cs_n = 1'b1; we_n = 1'b0; addr = 3'd6; wdata = 8'hC3;
        @(negedge clk); bus_idle();
        rd(6, "R2 write ignored with cs_n high");
        @(negedge clk);

        // hardware store with carried write, rejected fresh write, lockout
        cs_n = 1'b0; we_n = 1'b0; addr = 3'd2; wdata = 8'h11;
        @(negedge clk);
        wdata = 8'h22; ext_low = 1'b1;
        @(negedge clk);
        bus_idle();
        m_vol[2] = 8'h22;
        @(negedge clk);
        cs_n = 1'b0; we_n = 1'b0; addr = 3'd0; wdata = 8'hEE;
        @(negedge clk);
        bus_idle();
        store_window(3, "hw store");
        sw_store = 1'b1;            // R10: arrives while locked
        @(negedge clk);
        sw_store = 1'b0;
        @(negedge clk);
        ext_low = 1'b0;
        no_store(G + S + 3, "R10 command during lockout ignored");
        rd(0, "R8 fresh write refused");
        rd(2, "R7 carried write landed");

        // recall: R3, R11
        wr(2, 8'h33);
        recall_req = 1'b1;
        @(negedge clk);
        recall_req = 1'b0;
        rd_block(1, "R11 read blocked during recall");
        repeat (RC) @(negedge clk);
        for (int i = 0; i < DEPTH; i++) m_vol[i] = m_shd[i];
        rd(2, "R3 recall restores stored byte");
        rd(7, "R3 recall whole array");

        // R4/R5: flag cleared by recall, so both store requests are skipped
        ext_low = 1'b1;
        no_store(2, "R4 R5 hw request after recall");
        ext_low = 1'b0;
        pwr_fail = 1'b1;
        @(negedge clk);
        pwr_fail = 1'b0;
        no_store(G + S + 2, "R5 clean power-fail request");

        // R6: software store with clean flag
        sw_store = 1'b1;
        store_window(0, "R6 sw store clean");
        @(negedge clk);

        // R12 + R5: merged power-fail and software triggers with dirty flag
        wr(4, 8'h5A);
        pwr_fail = 1'b1; sw_store = 1'b1;
        store_window(0, "R12 R5 merged store");
        no_store(G + S + 3, "R12 single store only");
        wr(4, 8'h00);
        recall_req = 1'b1;
        @(negedge clk);
        recall_req = 1'b0;
        repeat (RC + 2) @(negedge clk);
        for (int i = 0; i < DEPTH; i++) m_vol[i] = m_shd[i];
        rd(4, "R3 R12 stored byte recalled");
        @(negedge clk);
        @(negedge clk);
        chk("R1 scoreboard drained", exp_q.size(), 0);
      end
    join_any
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule